// File: doc/BRIEF.md
# DAC Output Conditioning Stage

This block sits between a waveform source and a parallel digital-to-analog converter. Each signed sample is first multiplied by an unsigned fixed-point gain with sixteen fraction bits, so the gain runs from zero up to exactly one. A signed DC bias is then added, and the sum is clamped to the converter's range rather than allowed to wrap. The result can be reduced to twelve bits, with rounding, and placed in the upper bits of the output word. It can then be mirrored in polarity and presented either as two's complement or as offset-binary.

A small run/idle state machine follows the enable input. In the idle state the converter is held at its mid-scale code and the valid flag is low. In the run state the formatted samples pass through with a fixed latency. Setting the gain to zero turns the block into a programmable DC source.

Top module: `dac_condition`

States and transitions: `ST_IDLE` (mid-scale, valid low) goes to `ST_RUN` when `enable` is sampled high at a clock edge. `ST_RUN` (formatted data, valid follows the pipeline) returns to `ST_IDLE` when `enable` is sampled low.

## Requirements
- R1: The scaled value is (sample × gain + 32768) arithmetically shifted right by 16, where `gain` is an unsigned 17-bit value with 0x10000 meaning 1.0.
- R2: The DC bias is added to the scaled value, and the sum is clamped to the range −8192 to +8191.
- R3: With `gain` = 0, the output equals the DC bias, formatted like any other value.
- R4: When `narrow_en` = 1, the value v becomes (v + 2) >>> 2, limited to at most +2047. It is placed in `dac_data[13:2]`, and `dac_data[1:0]` is 0.
- R5: When `invert_en` = 1, the value after clamping and narrowing is negated. The most negative code (−8192, or −2048 in 12-bit mode) becomes the most positive code (+8191 or +2047).
- R6: When `twos_en` = 1, `dac_data` is two's complement. When `twos_en` = 0, bit 13 of the two's-complement word is inverted, giving offset-binary.
- R7: While idle (`enable` sampled low), `dac_data` is the mid-scale code and `dac_valid` is 0. Mid-scale is 0x2000 for offset-binary and 0x0000 for two's complement, chosen by `twos_en` sampled at the same edge.
- R8: A sample presented with `in_valid` appears on `dac_data`, with `dac_valid` = 1, three rising edges later. The bias is sampled one edge after the sample, and `narrow_en`, `invert_en`, `twos_en` and `enable` two edges after it. The gain is sampled together with the sample.
- R9: During reset, `dac_data` = 0x2000 and `dac_valid` = 0.
- R10: A `gain` value above 0x10000 is treated as exactly 0x10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_sample | input | 14 | Signed input sample |
| in_valid | input | 1 | Input sample valid |
| gain | input | 17 | Unsigned gain, 16 fraction bits |
| dc_bias | input | 14 | Signed DC bias |
| narrow_en | input | 1 | 1: 12-bit output mode |
| twos_en | input | 1 | 1: two's complement, 0: offset-binary |
| invert_en | input | 1 | 1: negate output polarity |
| enable | input | 1 | 1: run, 0: idle at mid-scale |
| dac_data | output | 14 | Converter data word |
| dac_valid | output | 1 | Converter data valid |

## Verification
The bench builds the block with its default widths: a 14-bit sample path, 16 fraction bits of gain and a 12-bit narrow mode. These values make both clamp limits, the +2048 rounding overflow and the two most-negative codes reachable with directed vectors. Random vectors cover all combinations of the format controls, with gains both below and above 1.0.

// File: rtl/dac_condition_pkg.sv
package dac_condition_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

endpackage

// File: rtl/dac_gain_stage.sv
module dac_gain_stage #(
    parameter int SW = 14,
    parameter int AF = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SW-1:0]        smp,
    input  logic                 vld_in,
    input  logic [AF:0]          gain,
    output logic signed [SW-1:0] scaled,
    output logic                 vld_out
);
    localparam int PW = SW + AF + 2;
    localparam logic [AF:0] UNITY = (AF+1)'(1) << AF;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (AF - 1);

    logic [AF:0]          gain_eff;
    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    always_comb begin
        gain_eff = (gain > UNITY) ? UNITY : gain;
        a_ext    = PW'($signed(smp));
        b_ext    = $signed(PW'(gain_eff));
        prod     = a_ext * b_ext;
        rnd      = (prod + HALF) >>> AF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scaled  <= '0;
            vld_out <= 1'b0;
        end else begin
            scaled  <= rnd[SW-1:0];
            vld_out <= vld_in;
        end
    end
endmodule

// File: rtl/dac_bias_stage.sv
module dac_bias_stage #(
    parameter int SW = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [SW-1:0] val_in,
    input  logic                 vld_in,
    input  logic [SW-1:0]        bias,
    output logic signed [SW-1:0] val_out,
    output logic                 vld_out
);
    localparam logic signed [SW:0] HI = (SW+1)'((1 << (SW - 1)) - 1);
    localparam logic signed [SW:0] LO = -((SW+1)'(1) << (SW - 1));

    logic signed [SW:0]   sum;
    logic signed [SW-1:0] clamped;

    always_comb begin
        sum = $signed({val_in[SW-1], val_in}) + $signed({bias[SW-1], bias});
        if (sum > HI)
            clamped = HI[SW-1:0];
        else if (sum < LO)
            clamped = LO[SW-1:0];
        else
            clamped = sum[SW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_out <= '0;
            vld_out <= 1'b0;
        end else begin
            val_out <= clamped;
            vld_out <= vld_in;
        end
    end
endmodule

// File: rtl/dac_format_stage.sv
module dac_format_stage #(
    parameter int SW = 14,
    parameter int NW = 12
) (
    input  logic signed [SW-1:0] val,
    input  logic                 narrow_en,
    input  logic                 invert_en,
    input  logic                 twos_en,
    output logic [SW-1:0]        code
);
    localparam int SH = SW - NW;
    localparam logic signed [SW-1:0] W_MAX = SW'((1 << (SW - 1)) - 1);
    localparam logic signed [SW-1:0] W_MIN = -(SW'(1) << (SW - 1));

    logic signed [SW-1:0] wide_v;
    logic [SW-1:0]        narrow_word;
    logic [SW-1:0]        tc_word;

    always_comb begin
        if (invert_en)
            wide_v = (val == W_MIN) ? W_MAX : -val;
        else
            wide_v = val;
    end

    generate
        if (SH > 0) begin : g_narrow
            localparam logic signed [NW-1:0] N_MAX = NW'((1 << (NW - 1)) - 1);
            localparam logic signed [NW-1:0] N_MIN = -(NW'(1) << (NW - 1));
            localparam logic signed [SW:0]   N_MAX_X = (SW+1)'((1 << (NW - 1)) - 1);
            localparam logic signed [SW:0]   RHALF = (SW+1)'(1) << (SH - 1);
            logic signed [SW:0]   rnd;
            logic signed [NW-1:0] lim;
            logic signed [NW-1:0] pol;
            always_comb begin
                rnd = ($signed({val[SW-1], val}) + RHALF) >>> SH;
                lim = (rnd > N_MAX_X) ? N_MAX : rnd[NW-1:0];
                if (invert_en)
                    pol = (lim == N_MIN) ? N_MAX : -lim;
                else
                    pol = lim;
                narrow_word = {pol, {SH{1'b0}}};
            end
        end else begin : g_no_narrow
            always_comb narrow_word = wide_v;
        end
    endgenerate

    always_comb begin
        tc_word = narrow_en ? narrow_word : wide_v;
        code    = twos_en ? tc_word : {~tc_word[SW-1], tc_word[SW-2:0]};
    end
endmodule

// File: rtl/dac_condition.sv
module dac_condition
    import dac_condition_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int GAIN_FRAC = 16,
    parameter int NARROW_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SAMPLE_W-1:0]   in_sample,
    input  logic                  in_valid,
    input  logic [GAIN_FRAC:0]    gain,
    input  logic [SAMPLE_W-1:0]   dc_bias,
    input  logic                  narrow_en,
    input  logic                  twos_en,
    input  logic                  invert_en,
    input  logic                  enable,
    output logic [SAMPLE_W-1:0]   dac_data,
    output logic                  dac_valid
);
    localparam logic [SAMPLE_W-1:0] MID_OB = SAMPLE_W'(1) << (SAMPLE_W - 1);
    localparam logic [SAMPLE_W-1:0] MID_TC = '0;

    logic signed [SAMPLE_W-1:0] scaled;
    logic                       vld_s1;
    logic signed [SAMPLE_W-1:0] biased;
    logic                       vld_s2;
    logic [SAMPLE_W-1:0]        code_c;

    logic [SAMPLE_W-1:0] code_q;
    logic                vld_q;
    logic                twos_q;
    run_state_t          state_q;
    run_state_t          state_next;

    dac_gain_stage #(.SW(SAMPLE_W), .AF(GAIN_FRAC)) u_gain (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (in_sample),
        .vld_in  (in_valid),
        .gain    (gain),
        .scaled  (scaled),
        .vld_out (vld_s1)
    );

    dac_bias_stage #(.SW(SAMPLE_W)) u_bias (
        .clk     (clk),
        .rst_n   (rst_n),
        .val_in  (scaled),
        .vld_in  (vld_s1),
        .bias    (dc_bias),
        .val_out (biased),
        .vld_out (vld_s2)
    );

    dac_format_stage #(.SW(SAMPLE_W), .NW(NARROW_W)) u_fmt (
        .val       (biased),
        .narrow_en (narrow_en),
        .invert_en (invert_en),
        .twos_en   (twos_en),
        .code      (code_c)
    );

    // Next-state selection: IDLE -> RUN on enable, RUN -> IDLE on !enable
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_next = enable ? ST_RUN : ST_IDLE;
            ST_RUN:  state_next = enable ? ST_RUN : ST_IDLE;
            default: state_next = ST_IDLE;
        endcase
    end

    // State register with the formatted word it qualifies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= MID_OB;
            vld_q   <= 1'b0;
            twos_q  <= 1'b0;
        end else begin
            state_q <= state_next;
            code_q  <= code_c;
            vld_q   <= vld_s2;
            twos_q  <= twos_en;
        end
    end

    // Output decode per state
    always_comb begin
        unique case (state_q)
            ST_RUN: begin
                dac_data  = code_q;
                dac_valid = vld_q;
            end
            default: begin
                dac_data  = twos_q ? MID_TC : MID_OB;
                dac_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dac_condition_chk.sv
module dac_condition_chk #(
    parameter int SAMPLE_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                narrow_en,
    input logic                twos_en,
    input logic                enable,
    input logic [SAMPLE_W-1:0] dac_data,
    input logic                dac_valid
);
    localparam logic [SAMPLE_W-1:0] MID_OB = SAMPLE_W'(1) << (SAMPLE_W - 1);

    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_IDLE_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!dac_valid && dac_data == ($past(twos_en) ? '0 : MID_OB))); // R7

    AST_NARROW_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && narrow_en) |=> (dac_data[1:0] == 2'b00)); // R4

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && dac_valid) |-> $past(in_valid, 3)); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && !enable && $past(!enable) && $stable(twos_en)) |=> $stable(dac_data)); // R7
endmodule

bind dac_condition dac_condition_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .narrow_en (narrow_en),
    .twos_en   (twos_en),
    .enable    (enable),
    .dac_data  (dac_data),
    .dac_valid (dac_valid)
);

// File: tb/dac_condition_tb_top.sv
`timescale 1ns/1ps
module dac_condition_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] in_sample = '0;
    logic        in_valid = 1'b0;
    logic [16:0] gain = '0;
    logic [13:0] dc_bias = '0;
    logic        narrow_en = 1'b0;
    logic        twos_en = 1'b0;
    logic        invert_en = 1'b0;
    logic        enable = 1'b0;
    logic [13:0] dac_data;
    logic        dac_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dac_condition dut_i (
        .clk(clk), .rst_n(rst_n), .in_sample(in_sample), .in_valid(in_valid),
        .gain(gain), .dc_bias(dc_bias), .narrow_en(narrow_en), .twos_en(twos_en),
        .invert_en(invert_en), .enable(enable), .dac_data(dac_data), .dac_valid(dac_valid)
    );

    function automatic int model(int s, int g, int b, bit nar, bit tw, bit inv, bit en);
        int gg, sc, sm, r, tc, code;
        if (!en) return tw ? 0 : 'h2000;
        gg = (g > 65536) ? 65536 : g;                 // R10
        sc = (s * gg + 32768) >>> 16;                 // R1
        sm = sc + b;                                  // R2
        if (sm > 8191) sm = 8191;
        if (sm < -8192) sm = -8192;
        if (nar) begin                                // R4
            r = (sm + 2) >>> 2;
            if (r > 2047) r = 2047;
            if (inv) r = (r == -2048) ? 2047 : -r;    // R5
            tc = r * 4;
        end else begin
            tc = inv ? ((sm == -8192) ? 8191 : -sm) : sm;
        end
        code = tc & 'h3fff;
        if (!tw) code = code ^ 'h2000;                // R6
        return code;
    endfunction

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic run_vec(string req, int s, int g, int b, bit nar, bit tw, bit inv, bit en);
        @(negedge clk);
        in_sample = 14'(s); gain = 17'(g); dc_bias = 14'(b);
        narrow_en = nar; twos_en = tw; invert_en = inv; enable = en; in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req, int'(dac_data), model(s, g, b, nar, tw, inv, en));
        check({req, " valid"}, int'(dac_valid), int'(en));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        check("R9 reset data", int'(dac_data), 'h2000);
        check("R9 reset valid", int'(dac_valid), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        run_vec("R1 unity gain", 1234, 65536, 0, 0, 1, 0, 1);
        run_vec("R1 half gain round", -3, 32768, 0, 0, 1, 0, 1);
        run_vec("R2 clamp high", 8191, 65536, 100, 0, 1, 0, 1);
        run_vec("R2 clamp low", -8192, 65536, -5, 0, 0, 0, 1);
        run_vec("R3 pure DC", 5000, 0, -300, 0, 1, 0, 1);
        run_vec("R3 pure DC ob", -7000, 0, 4000, 0, 0, 0, 1);
        run_vec("R4 narrow round max", 8191, 65536, 0, 1, 1, 0, 1);
        run_vec("R4 narrow round", 6, 65536, 0, 1, 1, 0, 1);
        run_vec("R5 invert min wide", -8192, 65536, 0, 0, 1, 1, 1);
        run_vec("R5 invert min narrow", -8192, 65536, 0, 1, 1, 1, 1);
        run_vec("R6 offset binary", -1, 65536, 0, 0, 0, 0, 1);
        run_vec("R7 idle ob", 999, 65536, 0, 0, 0, 0, 0);
        run_vec("R7 idle tc", 999, 65536, 0, 0, 1, 0, 0);
        run_vec("R10 gain over unity", 3000, 131071, 0, 0, 1, 0, 1);

        // R8: single-cycle valid pulse appears exactly three edges later
        @(negedge clk);
        in_valid = 1'b0; enable = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b1; in_sample = 14'd77; gain = 17'd65536; dc_bias = '0;
        narrow_en = 0; twos_en = 1; invert_en = 0;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R8 valid before", int'(dac_valid), 0);
        @(negedge clk);
        check("R8 valid at latency", int'(dac_valid), 1);
        check("R8 data at latency", int'(dac_data), 77);
        @(negedge clk);
        check("R8 valid after", int'(dac_valid), 0);

        for (int i = 0; i < 200; i++) begin
            int s, g, b;
            s = int'($signed(14'($urandom)));
            g = ($urandom % 4 == 0) ? int'($urandom % 131072) : int'($urandom % 65537);
            b = int'($signed(14'($urandom))) >>> ($urandom % 4);
            run_vec("R1 R2 R4 R5 R6 random", s, g, b, 1'($urandom), 1'($urandom),
                    1'($urandom), ($urandom % 8) != 0);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule